// File: doc/BRIEF.md
# Strobe-Scheduled Dual-Port Memory Sequencer

This block lets a slow asynchronous 16-bit cartridge bus and a local host share one memory that runs on a fast system clock. The cartridge read strobe and the two byte-lane write strobes pass through a single synchronising register. Their falling edges start a memory slot.

Every slot runs in the same fixed order. First comes the cartridge access. Next comes at most one waiting host request. The slot always ends with a refresh command. Because slots are tied to the strobes, the cartridge never waits behind the host, and its read latency stays short and fixed. Memory sees far more refresh commands than it needs. Cartridge writes are latched when the strobe falls and committed inside the slot, so the bus is never held up.

The block decodes its own address window from the upper cartridge address bits and has no chip-select input.

Top module: `cart_mem_sched`

## Requirements
- R1: While reset is applied and directly after it, `cart_rdata` is 0, `mem_cmd` is NOP (code 0), and `host_ready` and `host_rvalid` are low.
- R2: An access counts only when `cart_addr[7:6]` equals `WIN_SEL` (default 1). Any other address issues no memory command, leaves `cart_rdata` unchanged and writes nothing. The port list has no chip-select input.
- R3: When `cart_rd_n` falls, a READ command (code 1) goes out. The addressed word appears on `cart_rdata` at the sixth rising clock edge after the fall.
- R4: Memory read data is sampled at the end of the fourth cycle, counting the READ command cycle as the first. At the fifth rising edge after `cart_rd_n` falls, `cart_rdata` still holds its earlier value.
- R5: A fall of `cart_hiwr_n` or `cart_lowr_n` issues a WRITE command (code 2) inside the slot. On `mem_be`, bit 1 selects the high byte [15:8] and bit 0 the low byte [7:0]. Only the lanes whose strobes are low take the write.
- R6: The commands in a slot come in a fixed order: the cartridge command, then the host command if `host_valid` is high, then REFRESH (code 3), then NOP.
- R7: `host_ready` is high for at most one cycle per slot. A host read returns exactly one one-cycle `host_rvalid` pulse, with the word on `host_rdata`.
- R8: `cart_rdata` stays stable while `cart_rd_n` is low, except in the cycle a new read is captured.
- R9: Holding `cart_rd_n` low starts no further read. A new read needs the strobe to rise and fall again.
- R10: Every slot ends in a REFRESH, even when no host request is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cart_addr | input | 8 | Cartridge word address |
| cart_rd_n | input | 1 | Cartridge read strobe, active low |
| cart_hiwr_n | input | 1 | High-byte write strobe, active low |
| cart_lowr_n | input | 1 | Low-byte write strobe, active low |
| cart_wdata | input | 16 | Cartridge write data |
| cart_rdata | output | 16 | Read data held for the cartridge |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Host request accepted this cycle |
| host_addr | input | 6 | Host word address |
| host_we | input | 1 | Host write flag |
| host_be | input | 2 | Host byte enables |
| host_wdata | input | 16 | Host write data |
| host_rvalid | output | 1 | Host read data valid pulse |
| host_rdata | output | 16 | Host read data |
| mem_cmd | output | 2 | Memory command: 0 NOP, 1 READ, 2 WRITE, 3 REFRESH |
| mem_addr | output | 6 | Memory word address |
| mem_be | output | 2 | Memory byte enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |

## Verification
Some rules are checked by assertions on every cycle. These are the single grant per slot, the refresh that closes a slot with no host read, the NOP after each refresh, the one-cycle host response pulse, and the steady cartridge data while the read strobe is low. Other behaviour needs a memory model and a known history, so only the bench scenarios can show it. This covers the exact six-edge read latency, the byte-lane merge of writes, address-window rejection, the full command order of a slot, and the absence of a second read while the strobe is held low.

// File: rtl/cms_pkg.sv
package cms_pkg;
  typedef enum logic [1:0] {
    MC_NOP   = 2'd0,
    MC_READ  = 2'd1,
    MC_WRITE = 2'd2,
    MC_REF   = 2'd3
  } mcmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CRD, S_CWR, S_HOST, S_WAIT, S_REF
  } slot_e;
endpackage

// File: rtl/cms_sync.sv
module cms_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_n,
  output logic [W-1:0] lvl_n,
  output logic [W-1:0] fall
);
  logic [W-1:0] s_q, s_d, p_q, p_d;

  always_comb begin
    s_d = d_n;
    p_d = s_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '1;
      p_q <= '1;
    end else begin
      s_q <= s_d;
      p_q <= p_d;
    end
  end

  assign lvl_n = s_q;
  assign fall  = p_q & ~s_q;
endmodule

// File: rtl/cms_seq.sv
module cms_seq
  import cms_pkg::*;
#(
  parameter int MAW    = 6,
  parameter int DW     = 16,
  parameter int RD_LAT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_go,
  input  logic           wr_go,
  input  logic [MAW-1:0] c_addr,
  input  logic [1:0]     c_be,
  input  logic [DW-1:0]  c_wdata,
  input  logic           host_valid,
  input  logic [MAW-1:0] host_addr,
  input  logic           host_we,
  input  logic [1:0]     host_be,
  input  logic [DW-1:0]  host_wdata,
  output logic           host_ready,
  output logic [1:0]     mem_cmd,
  output logic [MAW-1:0] mem_addr,
  output logic [1:0]     mem_be,
  output logic [DW-1:0]  mem_wdata,
  output logic           cap_con,
  output logic           cap_host
);
  localparam int CW = (RD_LAT > 2) ? $clog2(RD_LAT) : 1;
  localparam logic [CW-1:0] WAIT_INIT = CW'(RD_LAT - 2);

  slot_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic own_q, own_d;
  mcmd_e cmd;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; own_d = own_q;
    host_ready = 1'b0; cmd = MC_NOP;
    mem_addr = c_addr; mem_be = c_be; mem_wdata = c_wdata;
    cap_con = 1'b0; cap_host = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (rd_go)      st_d = S_CRD;
        else if (wr_go) st_d = S_CWR;
      end
      S_CRD: begin
        cmd = MC_READ; mem_be = 2'b11;
        cnt_d = WAIT_INIT; own_d = 1'b0; st_d = S_WAIT;
      end
      S_CWR: begin
        cmd = MC_WRITE; st_d = S_HOST;
      end
      S_HOST: begin
        if (host_valid) begin
          host_ready = 1'b1;
          mem_addr = host_addr; mem_be = host_be; mem_wdata = host_wdata;
          if (host_we) begin
            cmd = MC_WRITE; st_d = S_REF;
          end else begin
            cmd = MC_READ; cnt_d = WAIT_INIT; own_d = 1'b1; st_d = S_WAIT;
          end
        end else begin
          st_d = S_REF;
        end
      end
      S_WAIT: begin
        if (cnt_q == '0) begin
          cap_con  = ~own_q;
          cap_host = own_q;
          st_d = own_q ? S_REF : S_HOST;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      S_REF: begin
        cmd = MC_REF; st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; own_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; own_q <= own_d;
    end
  end

  assign mem_cmd = cmd;

  // R7: a grant never repeats in the next cycle
  p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);
  // R10: a host phase without a host read leads straight into refresh
  p_ref_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HOST && !(host_valid && !host_we)) |=> mem_cmd == MC_REF);
  // R6: a refresh is the last command of its slot
  p_ref_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd == MC_REF |=> mem_cmd == MC_NOP);
endmodule

// File: rtl/cms_rdhold.sv
module cms_rdhold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_con,
  input  logic          cap_host,
  input  logic          rd_lvl_n,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] cart_rdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid
);
  logic [DW-1:0] crd_q, crd_d, hrd_q, hrd_d;
  logic          hv_q, hv_d;

  always_comb begin
    crd_d = cap_con  ? mem_rdata : crd_q;
    hrd_d = cap_host ? mem_rdata : hrd_q;
    hv_d  = cap_host;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crd_q <= '0; hrd_q <= '0; hv_q <= 1'b0;
    end else begin
      crd_q <= crd_d; hrd_q <= hrd_d; hv_q <= hv_d;
    end
  end

  assign cart_rdata  = crd_q;
  assign host_rdata  = hrd_q;
  assign host_rvalid = hv_q;

  // R8: cartridge data steady under a low read strobe unless captured
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lvl_n && !cap_con) |=> $stable(cart_rdata));
  // R7: host response is a single-cycle pulse
  p_rvalid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid);
endmodule

// File: rtl/cart_mem_sched.sv
module cart_mem_sched
  import cms_pkg::*;
#(
  parameter int BAW     = 8,
  parameter int MAW     = 6,
  parameter int DW      = 16,
  parameter int RD_LAT  = 4,
  parameter int WIN_SEL = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [BAW-1:0] cart_addr,
  input  logic           cart_rd_n,
  input  logic           cart_hiwr_n,
  input  logic           cart_lowr_n,
  input  logic [DW-1:0]  cart_wdata,
  output logic [DW-1:0]  cart_rdata,
  input  logic           host_valid,
  output logic           host_ready,
  input  logic [MAW-1:0] host_addr,
  input  logic           host_we,
  input  logic [1:0]     host_be,
  input  logic [DW-1:0]  host_wdata,
  output logic           host_rvalid,
  output logic [DW-1:0]  host_rdata,
  output logic [1:0]     mem_cmd,
  output logic [MAW-1:0] mem_addr,
  output logic [1:0]     mem_be,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata
);
  localparam int SW = BAW - MAW;
  localparam logic [SW-1:0] WIN = SW'(WIN_SEL);

  logic [1:0] rq;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rq <= 2'b00;
    else        rq <= {rq[0], 1'b1};
  end
  assign rst_i = rq[1];

  logic [2:0] lvl_n, fall;
  cms_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_i),
    .d_n({cart_rd_n, cart_hiwr_n, cart_lowr_n}),
    .lvl_n(lvl_n), .fall(fall)
  );

  logic [BAW-1:0] addr_s, addr_sd;
  logic [DW-1:0]  wd_s, wd_sd;
  logic [MAW-1:0] ca_q, ca_d;
  logic [1:0]     cb_q, cb_d;
  logic [DW-1:0]  cw_q, cw_d;
  logic hit, rd_go, wr_go, evt;

  always_comb begin
    addr_sd = cart_addr;
    wd_sd   = cart_wdata;
    hit   = (addr_s[BAW-1:MAW] == WIN);
    rd_go = fall[2] & hit;
    wr_go = (fall[1] | fall[0]) & hit;
    evt   = rd_go | wr_go;
    ca_d  = evt ? addr_s[MAW-1:0] : ca_q;
    cb_d  = evt ? (rd_go ? 2'b11 : ~lvl_n[1:0]) : cb_q;
    cw_d  = evt ? wd_s : cw_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      addr_s <= '0; wd_s <= '0; ca_q <= '0; cb_q <= '0; cw_q <= '0;
    end else begin
      addr_s <= addr_sd; wd_s <= wd_sd; ca_q <= ca_d; cb_q <= cb_d; cw_q <= cw_d;
    end
  end

  logic cap_con, cap_host;
  cms_seq #(.MAW(MAW), .DW(DW), .RD_LAT(RD_LAT)) u_seq (
    .clk(clk), .rst_n(rst_i), .rd_go(rd_go), .wr_go(wr_go),
    .c_addr(ca_q), .c_be(cb_q), .c_wdata(cw_q),
    .host_valid(host_valid), .host_addr(host_addr), .host_we(host_we),
    .host_be(host_be), .host_wdata(host_wdata), .host_ready(host_ready),
    .mem_cmd(mem_cmd), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .cap_con(cap_con), .cap_host(cap_host)
  );

  cms_rdhold #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_i), .cap_con(cap_con), .cap_host(cap_host),
    .rd_lvl_n(lvl_n[2]), .mem_rdata(mem_rdata),
    .cart_rdata(cart_rdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );
endmodule

// File: tb/sim_cart_mem_sched.sv
module sim_cart_mem_sched;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  cart_addr = '0;
  logic cart_rd_n = 1'b1, cart_hiwr_n = 1'b1, cart_lowr_n = 1'b1;
  logic [15:0] cart_wdata = '0;
  logic [15:0] cart_rdata;
  logic host_valid = 1'b0, host_we = 1'b0;
  logic host_ready, host_rvalid;
  logic [5:0]  host_addr = '0;
  logic [1:0]  host_be = 2'b11;
  logic [15:0] host_wdata = '0, host_rdata;
  logic [1:0]  mem_cmd, mem_be;
  logic [5:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cart_mem_sched u0 (
    .clk(clk), .rst_n(rst_n), .cart_addr(cart_addr), .cart_rd_n(cart_rd_n),
    .cart_hiwr_n(cart_hiwr_n), .cart_lowr_n(cart_lowr_n), .cart_wdata(cart_wdata),
    .cart_rdata(cart_rdata), .host_valid(host_valid), .host_ready(host_ready),
    .host_addr(host_addr), .host_we(host_we), .host_be(host_be),
    .host_wdata(host_wdata), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .mem_cmd(mem_cmd), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: READ data valid in the fourth cycle counting the command cycle
  logic [15:0] mem [64];
  logic p1v, p2v, p3v;
  logic [5:0] p1a, p2a, p3a;
  always @(posedge clk) begin
    p1v <= (mem_cmd == 2'd1); p1a <= mem_addr;
    p2v <= p1v; p2a <= p1a;
    p3v <= p2v; p3a <= p2a;
    if (mem_cmd == 2'd2) begin
      if (mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
      if (mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
    end
  end
  assign mem_rdata = p3v ? mem[p3a] : 16'h0000;

  // port monitor
  logic [1:0] lg [8];
  int n = 0, rdy_cnt = 0, rv_cnt = 0;
  logic [15:0] rv_data = '0;
  always @(negedge clk) begin
    if (mem_cmd != 2'd0 && n < 8) begin lg[n] = mem_cmd; n = n + 1; end
    if (host_ready) rdy_cnt = rdy_cnt + 1;
    if (host_rvalid) begin rv_cnt = rv_cnt + 1; rv_data = host_rdata; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    @(negedge clk);
    n = 0; rdy_cnt = 0; rv_cnt = 0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [15:0] early,
                         output logic [15:0] late, output logic [15:0] held);
    @(negedge clk);
    cart_addr = a; cart_rd_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); early = cart_rdata;
    @(posedge clk);
    @(negedge clk); late = cart_rdata;
    repeat (10) @(negedge clk);
    held = cart_rdata;
    cart_rd_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d,
                          input logic hi, input logic lo);
    @(negedge clk);
    cart_addr = a; cart_wdata = d; cart_hiwr_n = ~hi; cart_lowr_n = ~lo;
    repeat (3) @(negedge clk);
    cart_hiwr_n = 1'b1; cart_lowr_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cart_rdata", {16'h0, cart_rdata}, 32'h0);
    chk("R1 mem_cmd", {30'h0, mem_cmd}, 32'h0);
    chk("R1 host_ready", {31'h0, host_ready}, 32'h0);
    chk("R1 host_rvalid", {31'h0, host_rvalid}, 32'h0);
  endtask

  task automatic t_read_basic();
    logic [15:0] e, l, h;
    mem[5] = 16'hA5A5;
    clr();
    do_read({2'b01, 6'd5}, e, l, h);
    chk("R4 not yet at fifth edge", {16'h0, e}, 32'h0);
    chk("R3 data at sixth edge", {16'h0, l}, 32'hA5A5);
    chk("R8 held under low strobe", {16'h0, h}, 32'hA5A5);
    chk("R9 no retrigger count", n, 2);
    chk("R3 first cmd READ", {30'h0, lg[0]}, 32'd1);
    chk("R10 refresh without host", {30'h0, lg[1]}, 32'd3);
  endtask

  task automatic t_write();
    mem[9] = 16'h1111;
    clr();
    do_write({2'b01, 6'd9}, 16'hBEEF, 1'b1, 1'b0);
    chk("R5 high lane only", {16'h0, mem[9]}, 32'hBE11);
    chk("R5 cmd WRITE", {30'h0, lg[0]}, 32'd2);
    chk("R10 refresh after write", {30'h0, lg[1]}, 32'd3);
    do_write({2'b01, 6'd9}, 16'h2233, 1'b0, 1'b1);
    chk("R5 low lane only", {16'h0, mem[9]}, 32'hBE33);
  endtask

  task automatic t_host_write();
    logic [15:0] e, l, h;
    mem[20] = 16'h0000;
    host_addr = 6'd20; host_we = 1'b1; host_be = 2'b11; host_wdata = 16'h7777;
    host_valid = 1'b1;
    clr();
    do_read({2'b01, 6'd5}, e, l, h);
    host_valid = 1'b0;
    chk("R6 slot length", n, 3);
    chk("R6 order console", {30'h0, lg[0]}, 32'd1);
    chk("R6 order host", {30'h0, lg[1]}, 32'd2);
    chk("R6 order refresh", {30'h0, lg[2]}, 32'd3);
    chk("R7 one grant", rdy_cnt, 1);
    chk("R7 host write landed", {16'h0, mem[20]}, 32'h7777);
  endtask

  task automatic t_host_read();
    logic [15:0] e, l, h;
    mem[30] = 16'h4242;
    host_addr = 6'd30; host_we = 1'b0; host_valid = 1'b1;
    clr();
    do_read({2'b01, 6'd9}, e, l, h);
    host_valid = 1'b0;
    chk("R3 console data", {16'h0, l}, 32'hBE33);
    chk("R6 host READ second", {30'h0, lg[1]}, 32'd1);
    chk("R10 refresh last", {30'h0, lg[2]}, 32'd3);
    chk("R7 single rvalid", rv_cnt, 1);
    chk("R7 host data", {16'h0, rv_data}, 32'h4242);
  endtask

  task automatic t_miss();
    logic [15:0] e, l, h;
    mem[5] = 16'h5A5A;
    clr();
    do_read({2'b10, 6'd5}, e, l, h);
    do_write({2'b00, 6'd5}, 16'h0000, 1'b1, 1'b1);
    chk("R2 no commands", n, 0);
    chk("R2 read data kept", {16'h0, cart_rdata}, 32'hBE33);
    chk("R2 memory untouched", {16'h0, mem[5]}, 32'h5A5A);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_read_basic();
    t_write();
    t_host_write();
    t_host_read();
    t_miss();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule